// File: doc/BRIEF.md
# Raster Timing Control Register Block

This block is the control side of a programmable raster timing generator. A host writes byte registers over a simple bus: one control byte, fourteen timing bytes, and a status byte that it reads. From these registers the block runs a character-column counter and a line counter. It then produces horizontal and vertical sync, a composite blank, a video-enable gate and an interrupt at the start of vertical blank.

Three separate control bits gate the interrupt, the picture and the counters. The status byte reports the interrupt-pending flag. It also reports a monitor resolution sense code and a board identity code, both taken from external pins through a synchroniser.

Software blanks the screen with a read-modify-write of the control byte. It clears the video-enable bit, leaves the other bits as they were, and later sets the bit again to restore the picture. The pixel clock synthesiser, the pixel memory and the DAC are outside this block.

Top module: `raster_timing_ctl`

## Requirements
- R1: After a synchronous active-low reset, every register reads 0x00. `blank` is 1 and `hsync`, `vsync`, `video_on` and `irq` are 0.
- R2: The control byte is at offset 0x10. The timing bytes at 0x12..0x1F read back the value last written. In that address order they are: cursor start, cursor end, h blank start, h blank end, h sync start, h sync end, composite sync end, v blank start high, v blank start low, v blank end, v sync start, v sync end, holdoff start, holdoff end. Offsets 0x00..0x0F read 0x00 and ignore writes.
- R3: Status at offset 0x11 reads {pending, sense[2:0], id[3:0]}. Sense and id are the pin values after a two-flop synchroniser, so a pin change appears on the second clock edge after it. Writes never change sense or id.
- R4: `video_on` follows control bit 6. Writing the control byte with bit 6 changed and the other bits as read changes only that bit.
- R5: While control bit 5 is 0, the column, line and prescale counters are held at zero, `hsync` and `vsync` are 0 and `blank` is 1.
- R6: With bit 5 set, the column advances once every CHAR_CLKS clocks. The line ends after column hbe (0x15), or at once if the column is already above hbe. Horizontal blank holds while column >= hbs (0x14), and `hsync` is high while hss (0x16) <= column < hse (0x17).
- R7: The vertical blank start is vbs = {0x19, 0x1A}. The frame wraps after line vbs + vbe (0x1B). Vertical blank holds while line >= vbs. `vsync` is high during vertical blank while vss (0x1C) <= line - vbs < vse (0x1D).
- R8: `blank` = horizontal blank OR vertical blank OR NOT video enable (bit 6) OR NOT timing enable (bit 5).
- R9: Pending (status bit 7) is set on the clock edge that ends the first cycle of vertical blank. `irq` = pending AND control bit 7.
- R10: Any write to offset 0x11 clears pending unless a new vertical blank starts in the same cycle, in which case pending is set.
- R11: Control bits 4:0 and the cursor, composite sync and holdoff bytes are storage only: changing them alters no output pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe for the addressed byte |
| bus_addr | input | 5 | Byte offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| mon_sense | input | 3 | Monitor resolution sense pins (asynchronous) |
| board_id | input | 4 | Board identity pins (asynchronous) |
| hsync | output | 1 | Horizontal sync, active high |
| vsync | output | 1 | Vertical sync, active high |
| blank | output | 1 | Composite blank, active high |
| video_on | output | 1 | Video-enable gate |
| irq | output | 1 | Vertical-blank interrupt |

## Verification
The bench builds the block with CHAR_CLKS = 2 and SYNC_STAGES = 2. The short prescale keeps a line to a few tens of clocks, so many complete frames, several pending-set and clear races, and a blank start above line 255 (which uses the high byte) all fit in a short run. Timing bytes are rewritten mid-line to reach the early-wrap case where the column is already past the new line end.

// File: rtl/raster_pkg.sv
// Package: shared constants for the raster timing control block.
// Assumes a 5-bit byte offset space and byte-wide registers.
package raster_pkg;
    localparam int ADDR_W  = 5;
    localparam int DATA_W  = 8;
    localparam int VB_W    = 2 * DATA_W;   // vertical blank start spans two bytes
    localparam int NUM_TIM = 14;           // timing bytes at 0x12..0x1F
    localparam int SENSE_W = 3;
    localparam int ID_W    = 4;
    localparam int STAT_IN_W = SENSE_W + ID_W;

    localparam logic [ADDR_W-1:0] OFF_CTRL = 5'h10;
    localparam logic [ADDR_W-1:0] OFF_STAT = 5'h11;
    localparam logic [ADDR_W-1:0] OFF_TIM0 = 5'h12;

    // timing byte indices, relative to OFF_TIM0
    localparam int TI_HB_S  = 2;
    localparam int TI_HB_E  = 3;
    localparam int TI_HS_S  = 4;
    localparam int TI_HS_E  = 5;
    localparam int TI_VB_HI = 7;
    localparam int TI_VB_LO = 8;
    localparam int TI_VB_E  = 9;
    localparam int TI_VS_S  = 10;
    localparam int TI_VS_E  = 11;

    // control bit positions
    localparam int CB_IRQ_EN = 7;
    localparam int CB_VIDEO  = 6;
    localparam int CB_TIMING = 5;
endpackage

// File: rtl/raster_sense_sync.sv
// Module: multi-stage synchroniser for the monitor sense and board id pins.
// Assumes the pins change slowly compared with clk; no bus coherency is needed.
module raster_sense_sync #(
    parameter int WIDTH  = 7,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] stage_q [STAGES];

    generate
        for (genvar gs = 0; gs < STAGES; gs++) begin : g_stage
            if (gs == 0) begin : g_first
                // first stage samples the pins
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[0] <= '0;
                    else        stage_q[0] <= async_in;
                end
            end else begin : g_next
                // later stages settle the sampled value
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[gs] <= '0;
                    else        stage_q[gs] <= stage_q[gs-1];
                end
            end
        end
    endgenerate

    assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/raster_regfile.sv
// Module: host-visible register file: control byte, status byte, timing bytes.
// Assumes single-cycle writes and a combinational read path by offset.
// The pending flag lives here; a new vertical blank outranks a clear.
module raster_regfile
    import raster_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_wr,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [DATA_W-1:0]    bus_wdata,
    output logic [DATA_W-1:0]    bus_rdata,
    input  logic [STAT_IN_W-1:0] stat_in,
    input  logic                 vblank_rise,
    output logic                 irq_en,
    output logic                 video_en,
    output logic                 timing_en,
    output logic                 pending,
    output logic [DATA_W-1:0]    hb_s,
    output logic [DATA_W-1:0]    hb_e,
    output logic [DATA_W-1:0]    hs_s,
    output logic [DATA_W-1:0]    hs_e,
    output logic [VB_W-1:0]      vb_start,
    output logic [DATA_W-1:0]    vb_len,
    output logic [DATA_W-1:0]    vs_s,
    output logic [DATA_W-1:0]    vs_e
);
    logic [DATA_W-1:0] ctrl_q;
    logic [DATA_W-1:0] tim_q [NUM_TIM];
    logic              pend_q;
    logic [3:0]        tim_idx;
    logic              stat_wr;

    assign stat_wr = bus_wr && (bus_addr == OFF_STAT);
    assign tim_idx = 4'(bus_addr - OFF_TIM0);

    // control byte storage
    always_ff @(posedge clk) begin
        if (!rst_n)                                 ctrl_q <= '0;
        else if (bus_wr && (bus_addr == OFF_CTRL))  ctrl_q <= bus_wdata;
    end

    generate
        for (genvar gi = 0; gi < NUM_TIM; gi++) begin : g_tim
            // one timing byte per offset
            always_ff @(posedge clk) begin
                if (!rst_n)
                    tim_q[gi] <= '0;
                else if (bus_wr && (bus_addr == ADDR_W'(int'(OFF_TIM0) + gi)))
                    tim_q[gi] <= bus_wdata;
            end
        end
    endgenerate

    // interrupt pending: set at vertical blank start, cleared by status write
    always_ff @(posedge clk) begin
        if (!rst_n)           pend_q <= 1'b0;
        else if (vblank_rise) pend_q <= 1'b1;
        else if (stat_wr)     pend_q <= 1'b0;
    end

    // read multiplexer by byte offset
    always_comb begin
        bus_rdata = '0;
        if (bus_addr == OFF_CTRL)      bus_rdata = ctrl_q;
        else if (bus_addr == OFF_STAT) bus_rdata = {pend_q, stat_in};
        else if (bus_addr >= OFF_TIM0) bus_rdata = tim_q[tim_idx];
    end

    assign irq_en    = ctrl_q[CB_IRQ_EN];
    assign video_en  = ctrl_q[CB_VIDEO];
    assign timing_en = ctrl_q[CB_TIMING];
    assign pending   = pend_q;
    assign hb_s      = tim_q[TI_HB_S];
    assign hb_e      = tim_q[TI_HB_E];
    assign hs_s      = tim_q[TI_HS_S];
    assign hs_e      = tim_q[TI_HS_E];
    assign vb_start  = {tim_q[TI_VB_HI], tim_q[TI_VB_LO]};
    assign vb_len    = tim_q[TI_VB_E];
    assign vs_s      = tim_q[TI_VS_S];
    assign vs_e      = tim_q[TI_VS_E];
endmodule

// File: rtl/raster_counters.sv
// Module: prescaler, column counter and line counter of the raster.
// Assumes CHAR_CLKS >= 2. All counters are held at zero while en is low.
// A line ends after column hb_e; a frame ends after line vb_start + vb_len.
module raster_counters
    import raster_pkg::*;
#(
    parameter int CHAR_CLKS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [DATA_W-1:0] hb_e,
    input  logic [VB_W-1:0]   vb_start,
    input  logic [DATA_W-1:0] vb_len,
    output logic [DATA_W-1:0] h_col,
    output logic [VB_W-1:0]   v_line,
    output logic              char_last
);
    localparam int CW = (CHAR_CLKS > 1) ? $clog2(CHAR_CLKS) : 1;

    logic [CW-1:0]     char_q;
    logic [DATA_W-1:0] h_q;
    logic [VB_W-1:0]   v_q;
    logic [VB_W:0]     frame_last;
    logic              line_end;
    logic              frame_end;

    assign char_last  = (char_q == CW'(CHAR_CLKS - 1));
    assign frame_last = {1'b0, vb_start} + (VB_W+1)'(vb_len);
    assign line_end   = (h_q >= hb_e);
    assign frame_end  = ({1'b0, v_q} >= frame_last);

    // pixel prescaler: one column per CHAR_CLKS clocks
    always_ff @(posedge clk) begin
        if (!rst_n || !en)  char_q <= '0;
        else if (char_last) char_q <= '0;
        else                char_q <= char_q + 1'b1;
    end

    // column counter, wraps at the end of the line
    always_ff @(posedge clk) begin
        if (!rst_n || !en)  h_q <= '0;
        else if (char_last) h_q <= line_end ? '0 : h_q + 1'b1;
    end

    // line counter, advances at each line end and wraps at the frame end
    always_ff @(posedge clk) begin
        if (!rst_n || !en)
            v_q <= '0;
        else if (char_last && line_end)
            v_q <= frame_end ? '0 : v_q + 1'b1;
    end

    assign h_col  = h_q;
    assign v_line = v_q;
endmodule

// File: rtl/raster_sync_gen.sv
// Module: window compare for sync and blank, and vertical blank start detect.
// Assumes counters from raster_counters; all windows are inactive while en is low.
// Vertical sync is placed in lines counted from the start of vertical blank.
module raster_sync_gen
    import raster_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              video_en,
    input  logic [DATA_W-1:0] h_col,
    input  logic [VB_W-1:0]   v_line,
    input  logic [DATA_W-1:0] hb_s,
    input  logic [DATA_W-1:0] hs_s,
    input  logic [DATA_W-1:0] hs_e,
    input  logic [VB_W-1:0]   vb_start,
    input  logic [DATA_W-1:0] vs_s,
    input  logic [DATA_W-1:0] vs_e,
    output logic              hsync,
    output logic              vsync,
    output logic              blank,
    output logic              vblank_rise
);
    logic            hblank_w;
    logic            vblank_w;
    logic            vblank_q;
    logic [VB_W-1:0] v_rel;

    // window compares against the live counters
    always_comb begin
        v_rel    = v_line - vb_start;
        hblank_w = en && (h_col >= hb_s);
        vblank_w = en && (v_line >= vb_start);
        hsync    = en && (h_col >= hs_s) && (h_col < hs_e);
        vsync    = vblank_w && (v_rel >= VB_W'(vs_s)) && (v_rel < VB_W'(vs_e));
        blank    = !en || !video_en || hblank_w || vblank_w;
    end

    // previous vertical blank state for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) vblank_q <= 1'b0;
        else        vblank_q <= vblank_w;
    end

    assign vblank_rise = vblank_w && !vblank_q;
endmodule

// File: rtl/raster_timing_ctl.sv
// Module: top of the raster timing control register block.
// Assumes clk is the pixel clock; sense and id pins are asynchronous.
module raster_timing_ctl
    import raster_pkg::*;
#(
    parameter int CHAR_CLKS   = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_wr,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    input  logic [SENSE_W-1:0] mon_sense,
    input  logic [ID_W-1:0]    board_id,
    output logic               hsync,
    output logic               vsync,
    output logic               blank,
    output logic               video_on,
    output logic               irq
);
    logic [STAT_IN_W-1:0] stat_sync;
    logic                 irq_en, video_en, timing_en, pending, vblank_rise;
    logic [DATA_W-1:0]    hb_s, hb_e, hs_s, hs_e, vb_len, vs_s, vs_e;
    logic [VB_W-1:0]      vb_start;
    logic [DATA_W-1:0]    h_col;
    logic [VB_W-1:0]      v_line;
    logic                 char_last;

    raster_sense_sync #(.WIDTH(STAT_IN_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .async_in({mon_sense, board_id}), .sync_out(stat_sync)
    );

    raster_regfile u_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .stat_in(stat_sync), .vblank_rise(vblank_rise),
        .irq_en(irq_en), .video_en(video_en), .timing_en(timing_en), .pending(pending),
        .hb_s(hb_s), .hb_e(hb_e), .hs_s(hs_s), .hs_e(hs_e),
        .vb_start(vb_start), .vb_len(vb_len), .vs_s(vs_s), .vs_e(vs_e)
    );

    raster_counters #(.CHAR_CLKS(CHAR_CLKS)) u_cnt (
        .clk(clk), .rst_n(rst_n), .en(timing_en),
        .hb_e(hb_e), .vb_start(vb_start), .vb_len(vb_len),
        .h_col(h_col), .v_line(v_line), .char_last(char_last)
    );

    raster_sync_gen u_gen (
        .clk(clk), .rst_n(rst_n), .en(timing_en), .video_en(video_en),
        .h_col(h_col), .v_line(v_line),
        .hb_s(hb_s), .hs_s(hs_s), .hs_e(hs_e),
        .vb_start(vb_start), .vs_s(vs_s), .vs_e(vs_e),
        .hsync(hsync), .vsync(vsync), .blank(blank), .vblank_rise(vblank_rise)
    );

    assign video_on = video_en;
    assign irq      = pending && irq_en;
endmodule

// File: rtl/raster_timing_ctl_chk.sv
// Module: property checker bound to raster_timing_ctl.
module raster_timing_ctl_chk
    import raster_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              timing_en,
    input logic              video_en,
    input logic              irq_en,
    input logic [DATA_W-1:0] h_col,
    input logic [VB_W-1:0]   v_line,
    input logic              char_last,
    input logic              pending,
    input logic              vblank_rise,
    input logic              hsync,
    input logic              vsync,
    input logic              blank,
    input logic              irq
);
    AST_IDLE_COUNTERS: assert property (@(posedge clk) disable iff (!rst_n)
        !timing_en |=> (h_col == '0) && (v_line == '0)); // R5
    AST_IDLE_OUTPUTS: assert property (@(posedge clk) disable iff (!rst_n)
        !timing_en |-> (!hsync && !vsync && blank)); // R5
    AST_COLUMN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (timing_en && !char_last) |=> $stable(h_col)); // R6
    AST_DARK_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
        !video_en |-> blank); // R8
    AST_PEND_SET: assert property (@(posedge clk) disable iff (!rst_n)
        vblank_rise |=> pending); // R9
    AST_IRQ_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (irq_en && pending)); // R9
    AST_STATUS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && (bus_addr == OFF_STAT) && !vblank_rise) |=> !pending); // R10
endmodule

bind raster_timing_ctl raster_timing_ctl_chk u_chk (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .timing_en(timing_en), .video_en(video_en), .irq_en(irq_en),
    .h_col(h_col), .v_line(v_line), .char_last(char_last),
    .pending(pending), .vblank_rise(vblank_rise),
    .hsync(hsync), .vsync(vsync), .blank(blank), .irq(irq)
);

// File: tb/raster_timing_ctl_tb_top.sv
// Bench: behavioural reference model compared with the design on every clock.
module raster_timing_ctl_tb_top;
    localparam int CH = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0;
    logic [4:0] bus_addr = 5'h10;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic [2:0] mon_sense = 3'd0;
    logic [3:0] board_id = 4'd0;
    logic       hsync, vsync, blank, video_on, irq;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;
    string phase_tag = "";

    // reference model state
    int m_ctrl, m_ch, m_h, m_v, m_pend, m_vbp, m_s1, m_s2;
    int m_tim [14];

    always #5 clk = ~clk;

    raster_timing_ctl #(.CHAR_CLKS(CH), .SYNC_STAGES(2)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .mon_sense(mon_sense), .board_id(board_id),
        .hsync(hsync), .vsync(vsync), .blank(blank), .video_on(video_on), .irq(irq)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s%s at %0t: actual %0h expected %0h", req, phase_tag, $time, act, exp);
        end
    endtask

    function automatic int m_vbs();
        return m_tim[7] * 256 + m_tim[8];
    endfunction

    // model update at each rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_ctrl = 0; m_ch = 0; m_h = 0; m_v = 0; m_pend = 0; m_vbp = 0; m_s1 = 0; m_s2 = 0;
            for (int i = 0; i < 14; i++) m_tim[i] = 0;
        end else begin
            int ten, vb;
            ten = (m_ctrl >> 5) & 1;
            vb  = (ten != 0 && m_v >= m_vbs()) ? 1 : 0;
            if (vb == 1 && m_vbp == 0) m_pend = 1;
            else if (bus_wr && bus_addr == 5'h11) m_pend = 0;
            m_vbp = vb;
            if (ten == 0) begin
                m_ch = 0; m_h = 0; m_v = 0;
            end else if (m_ch == CH - 1) begin
                m_ch = 0;
                if (m_h >= m_tim[3]) begin
                    m_h = 0;
                    if (m_v >= m_vbs() + m_tim[9]) m_v = 0;
                    else m_v = (m_v + 1) % 65536;
                end else m_h = m_h + 1;
            end else m_ch = m_ch + 1;
            m_s2 = m_s1;
            m_s1 = {25'd0, mon_sense, board_id};
            if (bus_wr) begin
                if (bus_addr == 5'h10) m_ctrl = bus_wdata;
                else if (bus_addr >= 5'h12) m_tim[bus_addr - 5'h12] = bus_wdata;
            end
        end
    end

    // compare every cycle, well after the edge
    always @(posedge clk) begin
        #3;
        if (rst_n && !finished) begin
            int ten, vbs, hbl, vbl, rel, e_hs, e_vs, e_bl, e_rd;
            ten  = (m_ctrl >> 5) & 1;
            vbs  = m_vbs();
            hbl  = (ten != 0 && m_h >= m_tim[2]) ? 1 : 0;
            vbl  = (ten != 0 && m_v >= vbs) ? 1 : 0;
            rel  = m_v - vbs;
            e_hs = (ten != 0 && m_h >= m_tim[4] && m_h < m_tim[5]) ? 1 : 0;
            e_vs = (vbl != 0 && rel >= m_tim[10] && rel < m_tim[11]) ? 1 : 0;
            e_bl = (ten == 0 || ((m_ctrl >> 6) & 1) == 0 || hbl != 0 || vbl != 0) ? 1 : 0;
            if (bus_addr == 5'h10) e_rd = m_ctrl;
            else if (bus_addr == 5'h11) e_rd = m_pend * 128 + m_s2;
            else if (bus_addr >= 5'h12) e_rd = m_tim[bus_addr - 5'h12];
            else e_rd = 0;
            chk("R6 hsync", int'(hsync), e_hs);
            chk("R7 vsync", int'(vsync), e_vs);
            chk("R8 blank", int'(blank), e_bl);
            chk("R4 video_on", int'(video_on), (m_ctrl >> 6) & 1);
            chk("R9 irq", int'(irq), (m_pend != 0 && ((m_ctrl >> 7) & 1) != 0) ? 1 : 0);
            if (bus_addr == 5'h11) chk("R3 status", int'(bus_rdata), e_rd);
            else chk("R2 readback", int'(bus_rdata), e_rd);
        end
    end

    task automatic wr(input logic [4:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++; n_errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [7:0] rd;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 blank", int'(blank), 1);
        chk("R1 hsync", int'(hsync), 0);
        chk("R1 vsync", int'(vsync), 0);
        chk("R1 video_on", int'(video_on), 0);
        chk("R1 irq", int'(irq), 0);
        for (int a = 5'h10; a <= 5'h1F; a++) begin
            bus_addr = 5'(a); #1;
            if (a != 5'h11) chk("R1 reg", int'(bus_rdata), 0);
        end
        // R2 low offsets ignore writes
        wr(5'h05, 8'h5A);
        bus_addr = 5'h05; idle(2);
        chk("R2 low offset", int'(bus_rdata), 0);
        // timing setup: 10 columns, blank from 6, sync 7..8; vbs 5, 3 blank lines
        wr(5'h14, 8'd6); wr(5'h15, 8'd9); wr(5'h16, 8'd7); wr(5'h17, 8'd9);
        wr(5'h19, 8'd0); wr(5'h1A, 8'd5); wr(5'h1B, 8'd2);
        wr(5'h1C, 8'd0); wr(5'h1D, 8'd1);
        wr(5'h12, 8'h33); wr(5'h13, 8'h44); wr(5'h18, 8'h55); wr(5'h1E, 8'hFF); wr(5'h1F, 8'h01);
        for (int a = 5'h12; a <= 5'h1F; a++) begin
            bus_addr = 5'(a); idle(1);
        end
        wr(5'h10, 8'hE0);
        // R3 status with changing sense pins
        bus_addr = 5'h11;
        mon_sense = 3'd4; board_id = 4'd1; idle(200);
        mon_sense = 3'd6; idle(1);
        mon_sense = 3'd2; board_id = 4'd3; idle(200);
        wr(5'h11, 8'h00);            // R3 write does not touch sense/id
        bus_addr = 5'h11; idle(3);
        chk("R3 id", int'(bus_rdata[3:0]), 3);
        // R10 clear after the interrupt
        while (!irq) @(negedge clk);
        wr(5'h11, 8'hA5);
        bus_addr = 5'h11; #1;
        chk("R10 pending", int'(bus_rdata[7]), 0);
        chk("R10 irq", int'(irq), 0);
        // R10 clear racing every phase of the frame
        for (int k = 0; k < 170; k++) wr(5'h11, 8'h00);
        // R4 blank by read-modify-write
        bus_addr = 5'h10; #1; rd = bus_rdata;
        wr(5'h10, rd & 8'hBF);
        bus_addr = 5'h10; idle(2);
        chk("R4 keep bits", int'(bus_rdata), int'(rd & 8'hBF));
        chk("R4 blank", int'(blank), 1);
        idle(100);
        wr(5'h10, rd | 8'h40);
        idle(100);
        // R11 storage-only bytes and control bits
        phase_tag = " R11";
        wr(5'h10, 8'hFF); idle(60);
        wr(5'h10, 8'hEA); idle(60);
        wr(5'h12, 8'h00); wr(5'h13, 8'hFF); wr(5'h18, 8'h00); wr(5'h1E, 8'h00); idle(60);
        wr(5'h10, 8'hE0);
        phase_tag = "";
        // R5 timing disabled
        wr(5'h10, 8'hC0); idle(60);
        chk("R5 hsync", int'(hsync), 0);
        chk("R5 blank", int'(blank), 1);
        wr(5'h10, 8'hE0); idle(150);
        // R6 early wrap: shrink the line below the current column
        while (!(dut_i.hsync)) @(negedge clk);
        wr(5'h15, 8'd3); wr(5'h14, 8'd2); wr(5'h16, 8'd1); wr(5'h17, 8'd2);
        idle(100);
        // R7 blank start above line 255 (high byte 1), vsync 2..3 after it
        wr(5'h19, 8'd1); wr(5'h1A, 8'd2); wr(5'h1B, 8'd4);
        wr(5'h1C, 8'd2); wr(5'h1D, 8'd4);
        bus_addr = 5'h11; idle(5000);
        finish_run();
    end
endmodule